// File: doc/BRIEF.md
# Burst Line Fill Bus Master

This block is the read side of a cache's bus interface. A cache controller hands it a word address and a select that asks either for a whole line of four 32-bit words or for one word. For a line, the block runs one bus cycle with `bus_cyc` held high. It issues one strobed beat per word, from the line-aligned address upward in 4-byte steps. For a single word it runs one short beat. Every word that comes back is given to the cache one clock after its acknowledge, together with its position inside the line. A one-clock `done` pulse marks the last word.

A build-time parameter picks how the strobe is paced. The conservative mode drops the strobe for one clock after every acknowledge, so each beat costs two clocks. It also parks the bus for one idle clock after a single-word read. The fast mode is meant for on-chip SRAM that answers at once. It keeps the strobe high from beat to beat and advances the address on each acknowledge, so a line streams in one clock per beat. Writes, the cache arrays and tag lookup are handled elsewhere.

Top module: `line_fill_master`

## Requirements
- R1: After a synchronous active-low reset, `bus_cyc`, `bus_stb`, `rsp_valid` and `done` are low and `req_ready` is high.
- R2: A request is taken only on a clock where `req_valid` and `req_ready` are both high, and `req_ready` is high only while no transfer is in progress. A `req_valid` raised during a transfer starts no bus activity.
- R3: A line request (`req_line`=1) makes exactly four acknowledged beats at byte addresses {req_waddr[29:2], k, 2'b00} for k = 0, 1, 2, 3, in that order. Word k is returned with `rsp_idx` = k.
- R4: A single request (`req_line`=0) makes exactly one acknowledged beat at byte address {req_waddr, 2'b00}. The word is returned with `rsp_idx` = req_waddr[1:0].
- R5: While `bus_stb` is high and `bus_ack` is low, the strobe stays high and `bus_adr` does not change on the next clock.
- R6: In conservative mode (FAST_MODE=0), `bus_stb` is low on the clock after every acknowledge. With an immediately acknowledging slave, a line holds `bus_cyc` for 7 clocks, and the next request can be taken 8 clocks after the previous one.
- R7: In conservative mode, a single read holds `bus_cyc` for one clock when acknowledged at once. It is followed by one clock with `bus_cyc` low and `req_ready` low, so a new request is taken no sooner than 3 clocks later.
- R8: In fast mode (FAST_MODE=1), `bus_stb` stays high after each non-final acknowledge, with the address already advanced. With an immediately acknowledging slave, a line takes 4 strobed clocks and is done in the 5th clock after acceptance. A single read is done in the 2nd clock.
- R9: `bus_cyc` drops on the clock after the final acknowledge. `done` is high for exactly one clock, which is the clock after the final acknowledge, together with the last `rsp_valid`.
- R10: On the clock after each acknowledge, `rsp_valid` is high and `rsp_data` holds the `bus_rdata` seen at that acknowledge. On every other clock `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Cache asks for a transfer |
| req_ready | output | 1 | Block is idle and will take a request this clock |
| req_waddr | input | ADDR_W-2 (30) | Word address of the requested word |
| req_line | input | 1 | 1: fetch the whole line, 0: fetch one word |
| rsp_valid | output | 1 | A returned word is present |
| rsp_data | output | DATA_W (32) | Returned word |
| rsp_idx | output | log2(LINE_WORDS) (2) | Position of the returned word in its line |
| done | output | 1 | One-clock pulse with the last word of a transfer |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_stb | output | 1 | Beat strobe |
| bus_adr | output | ADDR_W (32) | Byte address of the current beat |
| bus_rdata | input | DATA_W (32) | Read data from the slave |
| bus_ack | input | 1 | Slave acknowledges the current beat |

## Verification
The hardest case to reach from the ports is a slave that stretches beats while the fast mode streams. Here the address must freeze under a held strobe, and it must still advance by exactly one word when the late acknowledge comes. The bench's slave model stretches every beat by a programmable number of wait clocks, and it compares the address at each stretched clock with the address at the acknowledge. A second hard case is a request that arrives mid-transfer. The bench raises `req_valid` with a different address in the first busy clock, then watches that no extra beat or bus cycle follows.

// File: rtl/lfm_pkg.sv
// Shared types for the line fill bus master.
// Assumes: a single clock domain; the enum is only used inside the block.
package lfm_pkg;

    // Sequencer states: idle, strobed beat, strobe-low gap, post-single recovery
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BEAT    = 2'd1,
        ST_GAP     = 2'd2,
        ST_RECOVER = 2'd3
    } lfm_state_t;

endpackage

// File: rtl/lfm_seq.sv
// Transfer sequencer: owns the bus cycle and strobe pacing.
// FAST_MODE=0 inserts a strobe-low clock after each non-final acknowledge and
// one cyc-low recovery clock after a single-word read; FAST_MODE=1 streams.
// Assumes the slave only acknowledges while the strobe is high.
module lfm_seq
    import lfm_pkg::*;
#(
    parameter bit FAST_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_fire,
    input  logic cur_line,
    input  logic last_beat,
    input  logic bus_ack,
    output logic bus_cyc,
    output logic bus_stb,
    output logic req_ready,
    output logic beat_ack,
    output logic final_ack
);

    lfm_state_t state;
    lfm_state_t state_nxt;

    // Decode bus controls and acknowledge events from the current state
    always_comb begin
        bus_stb   = (state == ST_BEAT);
        bus_cyc   = (state == ST_BEAT) || (state == ST_GAP);
        req_ready = (state == ST_IDLE);
        beat_ack  = bus_stb && bus_ack;
        final_ack = beat_ack && last_beat;
    end

    // Choose the next state from the pacing mode and the beat position
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE: begin
                if (req_fire) state_nxt = ST_BEAT;
            end
            ST_BEAT: begin
                if (bus_ack) begin
                    if (last_beat)
                        state_nxt = (FAST_MODE || cur_line) ? ST_IDLE : ST_RECOVER;
                    else
                        state_nxt = FAST_MODE ? ST_BEAT : ST_GAP;
                end
            end
            ST_GAP:     state_nxt = ST_BEAT;
            ST_RECOVER: state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |=> (bus_stb && !req_ready)); // R2
    AST_WAIT_HOLDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_ack) |=> bus_stb); // R5
    AST_CYC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        final_ack |=> !bus_cyc); // R9

    generate
        if (FAST_MODE) begin : g_fast_chk
            AST_FAST_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
                (beat_ack && !last_beat) |=> bus_stb); // R8
        end else begin : g_reg_chk
            AST_REG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                beat_ack |=> !bus_stb); // R6
            AST_REG_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
                (final_ack && !cur_line) |=> (!bus_cyc && !req_ready)); // R7
        end
    endgenerate

endmodule

// File: rtl/lfm_addr.sv
// Beat address generator: latches the request, walks the word index of a line
// from zero upward, and flags the final beat. A single read keeps the index
// of the requested word. Assumes LINE_WORDS is a power of two.
module lfm_addr #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_fire,
    input  logic                                 req_line,
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]   req_waddr,
    input  logic                                 beat_ack,
    input  logic                                 bus_stb,
    input  logic                                 bus_ack,
    output logic [ADDR_W-1:0]                    bus_adr,
    output logic [$clog2(LINE_WORDS)-1:0]        cur_idx,
    output logic                                 cur_line,
    output logic                                 last_beat
);

    localparam int BYTE_OFF = $clog2(DATA_W/8);
    localparam int IDX_W    = $clog2(LINE_WORDS);
    localparam int WA_W     = ADDR_W - BYTE_OFF;
    localparam int HI_W     = WA_W - IDX_W;

    logic [HI_W-1:0]  line_hi;
    logic [IDX_W-1:0] widx;

    // Latch the line base and start index; step the index on each non-final ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_hi  <= '0;
            widx     <= '0;
            cur_line <= 1'b0;
        end else if (req_fire) begin
            line_hi  <= req_waddr[WA_W-1:IDX_W];
            widx     <= req_line ? '0 : req_waddr[IDX_W-1:0];
            cur_line <= req_line;
        end else if (beat_ack && !last_beat) begin
            widx <= widx + 1'b1;
        end
    end

    // Form the byte address and the final-beat flag
    always_comb begin
        bus_adr   = {line_hi, widx, {BYTE_OFF{1'b0}}};
        cur_idx   = widx;
        last_beat = !cur_line || (widx == {IDX_W{1'b1}});
    end

    AST_ADR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ack && !last_beat) |=>
            (bus_adr[BYTE_OFF +: IDX_W] == $past(bus_adr[BYTE_OFF +: IDX_W]) + 1'b1)
            && (bus_adr[ADDR_W-1:BYTE_OFF+IDX_W] == $past(bus_adr[ADDR_W-1:BYTE_OFF+IDX_W]))); // R3
    AST_ADR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_ack) |=> $stable(bus_adr)); // R5

endmodule

// File: rtl/lfm_capture.sv
// Response stage: registers each acknowledged word with its line index and
// raises done together with the last word. Assumes acks arrive only on
// strobed clocks (beat_ack already qualifies them).
module lfm_capture #(
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          beat_ack,
    input  logic                          final_ack,
    input  logic [DATA_W-1:0]             bus_rdata,
    input  logic [$clog2(LINE_WORDS)-1:0] cur_idx,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_data,
    output logic [$clog2(LINE_WORDS)-1:0] rsp_idx,
    output logic                          done
);

    // Capture data on an acknowledge; valid and done last one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_idx   <= '0;
            done      <= 1'b0;
        end else begin
            rsp_valid <= beat_ack;
            done      <= final_ack;
            if (beat_ack) begin
                rsp_data <= bus_rdata;
                rsp_idx  <= cur_idx;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rsp_valid); // R9
    AST_RSP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ack |=> (rsp_valid && (rsp_data == $past(bus_rdata)))); // R10
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_ack |=> !rsp_valid); // R10

endmodule

// File: rtl/line_fill_master.sv
// Line fill bus master: takes line or single-word read requests from a cache
// controller and runs them as read cycles on a single-master bus.
// FAST_MODE selects back-to-back streaming for a zero-wait on-chip SRAM;
// otherwise each beat is followed by a strobe-low clock.
// Assumes word-granular requests (no byte offset is carried).
module line_fill_master #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter bit FAST_MODE  = 1'b0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]  req_waddr,
    input  logic                                req_line,
    output logic                                rsp_valid,
    output logic [DATA_W-1:0]                   rsp_data,
    output logic [$clog2(LINE_WORDS)-1:0]       rsp_idx,
    output logic                                done,
    output logic                                bus_cyc,
    output logic                                bus_stb,
    output logic [ADDR_W-1:0]                   bus_adr,
    input  logic [DATA_W-1:0]                   bus_rdata,
    input  logic                                bus_ack
);

    localparam int IDX_W = $clog2(LINE_WORDS);

    logic             req_fire;
    logic             cur_line;
    logic             last_beat;
    logic             beat_ack;
    logic             final_ack;
    logic [IDX_W-1:0] cur_idx;

    // Handshake: a request is taken only while idle
    always_comb req_fire = req_valid && req_ready;

    lfm_seq #(
        .FAST_MODE (FAST_MODE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .cur_line  (cur_line),
        .last_beat (last_beat),
        .bus_ack   (bus_ack),
        .bus_cyc   (bus_cyc),
        .bus_stb   (bus_stb),
        .req_ready (req_ready),
        .beat_ack  (beat_ack),
        .final_ack (final_ack)
    );

    lfm_addr #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .req_line  (req_line),
        .req_waddr (req_waddr),
        .beat_ack  (beat_ack),
        .bus_stb   (bus_stb),
        .bus_ack   (bus_ack),
        .bus_adr   (bus_adr),
        .cur_idx   (cur_idx),
        .cur_line  (cur_line),
        .last_beat (last_beat)
    );

    lfm_capture #(
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_ack  (beat_ack),
        .final_ack (final_ack),
        .bus_rdata (bus_rdata),
        .cur_idx   (cur_idx),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_idx   (rsp_idx),
        .done      (done)
    );

endmodule

// File: tb/sim_line_fill_master.sv
`timescale 1ns/1ps
// Directed bench: u0 runs conservative pacing, u1 fast pacing. Each has its
// own slave model with a programmable number of wait clocks per beat.
module sim_line_fill_master;

    localparam logic [31:0] KEY = 32'h5A00_00C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid [2];
    logic        req_ready [2];
    logic [29:0] req_waddr [2];
    logic        req_line  [2];
    logic        rsp_valid [2];
    logic [31:0] rsp_data  [2];
    logic [1:0]  rsp_idx   [2];
    logic        done      [2];
    logic        bus_cyc   [2];
    logic        bus_stb   [2];
    logic [31:0] bus_adr   [2];
    logic [31:0] bus_rdata [2];
    logic        bus_ack   [2];
    int          wcnt      [2];
    int          wait_cfg  [2];

    int          vec = 0;
    int          miss = 0;
    int          cyc_n [2];
    int          b_n [2];
    int          r_n [2];
    int          hold_bad [2];
    bit          held_v [2];
    logic [31:0] held [2];
    logic [31:0] b_adr [2][8];
    logic [1:0]  r_idx [2][8];
    logic [31:0] r_dat [2][8];

    always #10 clk = ~clk;

    line_fill_master #(.FAST_MODE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
        .req_waddr(req_waddr[0]), .req_line(req_line[0]), .rsp_valid(rsp_valid[0]),
        .rsp_data(rsp_data[0]), .rsp_idx(rsp_idx[0]), .done(done[0]),
        .bus_cyc(bus_cyc[0]), .bus_stb(bus_stb[0]), .bus_adr(bus_adr[0]),
        .bus_rdata(bus_rdata[0]), .bus_ack(bus_ack[0]));

    line_fill_master #(.FAST_MODE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
        .req_waddr(req_waddr[1]), .req_line(req_line[1]), .rsp_valid(rsp_valid[1]),
        .rsp_data(rsp_data[1]), .rsp_idx(rsp_idx[1]), .done(done[1]),
        .bus_cyc(bus_cyc[1]), .bus_stb(bus_stb[1]), .bus_adr(bus_adr[1]),
        .bus_rdata(bus_rdata[1]), .bus_ack(bus_ack[1]));

    // Slave model: ack after wait_cfg stretched clocks, data is a function of address
    always_comb begin
        for (int d = 0; d < 2; d++) begin
            bus_ack[d]   = bus_cyc[d] && bus_stb[d] && (wcnt[d] >= wait_cfg[d]);
            bus_rdata[d] = bus_adr[d] ^ KEY;
        end
    end

    always_ff @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) wcnt[d] <= 0;
            else if (bus_stb[d] && !bus_ack[d]) wcnt[d] <= wcnt[d] + 1;
            else wcnt[d] <= 0;
        end
    end

    // Monitor: log beats, responses, cyc clocks and address holds between edges
    always @(negedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (bus_cyc[d]) cyc_n[d]++;
            if (bus_stb[d] && bus_ack[d]) begin
                if (held_v[d] && held[d] != bus_adr[d]) hold_bad[d]++;
                held_v[d] = 1'b0;
                if (b_n[d] < 8) b_adr[d][b_n[d]] = bus_adr[d];
                b_n[d]++;
            end else if (bus_stb[d]) begin
                if (held_v[d] && held[d] != bus_adr[d]) hold_bad[d]++;
                held[d]   = bus_adr[d];
                held_v[d] = 1'b1;
            end
            if (rsp_valid[d]) begin
                if (r_n[d] < 8) begin
                    r_idx[d][r_n[d]] = rsp_idx[d];
                    r_dat[d][r_n[d]] = rsp_data[d];
                end
                r_n[d]++;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        vec++;
        if (!ok) begin
            miss++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One transfer on DUT d with w wait clocks per beat; poke raises a request mid-transfer
    task automatic run(input int d, input logic [29:0] wa, input bit line,
                       input int w, input bit poke, input string tg);
        int beats, cyc_e, done_e, rdy_e, n, done_at, rdy_at, cyc_keep, b_keep;
        string trq, arq;
        logic [31:0] ea;
        logic [1:0]  ei;
        beats  = line ? 4 : 1;
        cyc_e  = (d == 1) ? beats * (1 + w) : beats * (1 + w) + beats - 1;
        done_e = cyc_e + 1;
        rdy_e  = (d == 0 && !line) ? done_e + 1 : done_e;
        trq    = (d == 1) ? "R8" : (line ? "R6" : "R7");
        arq    = line ? "R3" : "R4";
        wait_cfg[d] = w;
        @(negedge clk);
        chk(req_ready[d] == 1'b1, "R2", {tg, " ready before request"}, req_ready[d], 1);
        req_waddr[d] = wa;
        req_line[d]  = line;
        req_valid[d] = 1'b1;
        @(posedge clk);
        cyc_n[d] = 0; b_n[d] = 0; r_n[d] = 0; hold_bad[d] = 0; held_v[d] = 1'b0;
        @(negedge clk);
        n = 1;
        if (poke) req_waddr[d] = ~wa;
        else req_valid[d] = 1'b0;
        done_at = 0;
        rdy_at  = 0;
        while (rdy_at == 0 && n < 300) begin
            if (done[d] && done_at == 0) done_at = n;
            if (req_ready[d]) rdy_at = n;
            else begin
                @(negedge clk);
                n++;
                req_valid[d] = 1'b0;
            end
        end
        #1;
        chk(done_at == done_e, "R9", {tg, " done clock"}, done_at, done_e);
        chk(rdy_at == rdy_e, trq, {tg, " ready again clock"}, rdy_at, rdy_e);
        chk(cyc_n[d] == cyc_e, trq, {tg, " cyc clocks"}, cyc_n[d], cyc_e);
        chk(b_n[d] == beats, arq, {tg, " beat count"}, b_n[d], beats);
        chk(r_n[d] == beats, "R10", {tg, " response count"}, r_n[d], beats);
        chk(hold_bad[d] == 0, "R5", {tg, " address held in wait"}, hold_bad[d], 0);
        for (int k = 0; k < beats && k < 8; k++) begin
            ea = line ? {wa[29:2], 2'(k), 2'b00} : {wa, 2'b00};
            ei = line ? 2'(k) : wa[1:0];
            chk(b_adr[d][k] == ea, arq, {tg, " beat address"}, b_adr[d][k], ea);
            chk(r_idx[d][k] == ei, arq, {tg, " word index"}, r_idx[d][k], ei);
            chk(r_dat[d][k] == (ea ^ KEY), "R10", {tg, " word data"}, r_dat[d][k], ea ^ KEY);
        end
        cyc_keep = cyc_n[d];
        b_keep   = b_n[d];
        repeat (3) @(negedge clk);
        #1;
        if (poke) begin
            chk(cyc_n[d] == cyc_keep, "R2", {tg, " busy request ignored (cyc)"}, cyc_n[d], cyc_keep);
            chk(b_n[d] == b_keep, "R2", {tg, " busy request ignored (beats)"}, b_n[d], b_keep);
        end
    endtask

    task automatic test_reset;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(bus_cyc[d] == 1'b0, "R1", "reset cyc", bus_cyc[d], 0);
            chk(bus_stb[d] == 1'b0, "R1", "reset stb", bus_stb[d], 0);
            chk(rsp_valid[d] == 1'b0, "R1", "reset rsp_valid", rsp_valid[d], 0);
            chk(done[d] == 1'b0, "R1", "reset done", done[d], 0);
            chk(req_ready[d] == 1'b1, "R1", "reset ready", req_ready[d], 1);
        end
    endtask

    task automatic test_reg_line;
        run(0, 30'h0001_2345, 1'b1, 0, 1'b0, "reg line a");
        run(0, 30'h3FFF_FFFF, 1'b1, 0, 1'b0, "reg line top");
    endtask

    task automatic test_reg_single;
        run(0, 30'h0000_0007, 1'b0, 0, 1'b0, "reg single a");
        run(0, 30'h2AAA_AAAA, 1'b0, 0, 1'b0, "reg single b");
    endtask

    task automatic test_fast_line;
        run(1, 30'h0ABC_DEF1, 1'b1, 0, 1'b0, "fast line a");
        run(1, 30'h0000_0002, 1'b1, 0, 1'b0, "fast line b");
    endtask

    task automatic test_fast_single;
        run(1, 30'h1234_5679, 1'b0, 0, 1'b0, "fast single a");
        run(1, 30'h0000_0000, 1'b0, 0, 1'b0, "fast single b");
    endtask

    task automatic test_waits;
        run(0, 30'h0055_0013, 1'b1, 2, 1'b0, "reg line wait2");
        run(1, 30'h0066_0021, 1'b1, 1, 1'b0, "fast line wait1");
        run(1, 30'h0077_0003, 1'b0, 3, 1'b0, "fast single wait3");
    endtask

    task automatic test_busy;
        run(0, 30'h0100_0008, 1'b1, 0, 1'b1, "reg line poke");
        run(1, 30'h0200_000C, 1'b1, 0, 1'b1, "fast line poke");
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            req_valid[d] = 1'b0;
            req_waddr[d] = '0;
            req_line[d]  = 1'b0;
            wait_cfg[d]  = 0;
            cyc_n[d] = 0; b_n[d] = 0; r_n[d] = 0; hold_bad[d] = 0; held_v[d] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_reg_line();
        test_reg_single();
        test_fast_line();
        test_fast_single();
        test_waits();
        test_busy();
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miss++;
        $display("FAIL R1 watchdog: actual %0d clocks expected completion sooner", 100000);
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

endmodule